// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block accepts configuration words over a three-line serial link made of a serial clock, a data line and a latch enable. All three lines are asynchronous to the system clock. They pass through a synchronizer, and their edges are detected in the system clock domain. Data bits enter a shift register on each rising edge of the serial clock, most significant bit first. When latch enable rises, a complete word is written into one of sixteen configuration registers. The register is chosen by the address held in the low four bits of the word.

The contents of all sixteen registers are presented in parallel on one wide output bus. Writing the calibration register (address 15) starts a calibration pulse on every write, including a write that repeats the stored value. A frame of the wrong length is dropped, and an error pulse is raised for it. The serial link is idle when all three lines are low.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, every configuration register reads zero, and `cal_start_o` and `frame_err_o` are low.
- R2: A frame is 32 bits sent MSB first. Bits [3:0] hold the target address and bits [31:4] hold the 28-bit value. Register `a` appears on `cfg_regs_o[a*28 +: 28]`.
- R3: The data line is sampled at each rising edge of the serial clock. Changes of the data line while the serial clock is high, or at its falling edge, do not affect the stored word.
- R4: If latch enable rises after a bit count other than 32, the frame is discarded. All registers keep their values, and `frame_err_o` is high for exactly one system clock cycle.
- R5: Every complete frame addressed to register 15 produces a `cal_start_o` pulse exactly one cycle long, including a frame that writes the value already stored. The pulse goes high in the cycle after the one in which the new register value first appears.
- R6: A frame addressed to any register other than 15 produces no `cal_start_o` pulse.
- R7: The bit counter clears while latch enable is high, and serial clock edges seen while latch enable is high are not counted. A frame that follows a discarded one is accepted normally.
- R8: A write changes only the addressed register. The other fifteen keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock (asynchronous) |
| ser_data_i | input | 1 | Serial data (asynchronous) |
| ser_latch_i | input | 1 | Latch enable (asynchronous) |
| cfg_regs_o | output | 448 | All sixteen 28-bit registers, register `a` at bits `[a*28 +: 28]` |
| cal_start_o | output | 1 | One-cycle calibration start strobe |
| frame_err_o | output | 1 | One-cycle pulse for a discarded frame |

## Verification
The assertions assume that the serial lines change slowly compared with the system clock. After synchronization, no two of the three lines may show an edge in the same cycle, and the data line must never move in the same cycle as a serial clock edge. The bench meets this by holding every line level for at least two system clock cycles between changes. It changes data three cycles before a serial clock rise, and it lowers data well before raising latch enable. Under these conditions, every sampled bit is the level that was set before its clock edge.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DEF_FRAME_W = 32;
  localparam int DEF_ADDR_W  = 4;
  localparam int DEF_SYNC    = 2;
  localparam int DEF_CAL_REG = 15;

  // Field split of a completed frame: address low, value high.
  function automatic int frame_value_lsb(input int addr_w);
    return addr_w;
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 32,
  parameter int ADDR_W  = 4,
  localparam int DATA_W = FRAME_W - ADDR_W,
  localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_rise_i,
  input  logic              bit_val_i,
  input  logic              latch_lvl_i,
  input  logic              latch_rise_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              err_stb_o
);
  import cfg_port_pkg::*;

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_W + 1);
  localparam int VAL_LSB = frame_value_lsb(ADDR_W);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               frame_full;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return (c == OVER_CNT) ? c : c + 1'b1;
  endfunction

  assign frame_full = (cnt_q == FULL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (latch_lvl_i) begin
      cnt_q <= '0;
    end else if (bit_rise_i) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], bit_val_i};
      cnt_q   <= next_count(cnt_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_o  <= 1'b0;
      err_stb_o <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o  <= latch_rise_i && frame_full;
      err_stb_o <= latch_rise_i && !frame_full;
      if (latch_rise_i && frame_full) begin
        wr_addr_o <= shreg_q[ADDR_W-1:0];
        wr_data_o <= shreg_q[FRAME_W-1:VAL_LSB];
      end
    end
  end

  // R7
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_lvl_i |=> (cnt_q == '0));
  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= OVER_CNT);
  // R4
  wr_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_o && err_stb_o));
  // R4
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_stb_o |=> !err_stb_o);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 28,
  parameter int CAL_REG = 15,
  localparam int NUM_REGS = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_stb_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       cal_o
);
  localparam logic [ADDR_W-1:0] CAL_ADDR = ADDR_W'(CAL_REG);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              cal_pend_q;
  logic              cal_q;
  logic              cal_hit;

  assign cal_hit = wr_stb_i && (wr_addr_i == CAL_ADDR);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      regs_q[g] <= '0;
      else if (wr_stb_i && wr_addr_i == ADDR_W'(g))     regs_q[g] <= wr_data_i;
    end
    assign regs_o[g*DATA_W +: DATA_W] = regs_q[g];

    // R8
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_stb_i && wr_addr_i == ADDR_W'(g)) |=> $stable(regs_o[g*DATA_W +: DATA_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_pend_q <= 1'b0;
      cal_q      <= 1'b0;
    end else begin
      cal_pend_q <= cal_hit;
      cal_q      <= cal_pend_q;
    end
  end

  assign cal_o = cal_q;

  // R5
  cal_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> ($past(wr_stb_i, 2) && $past(wr_addr_i, 2) == CAL_ADDR));
  // R5
  cal_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |=> !cal_o);
  // R6
  cal_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && wr_addr_i != CAL_ADDR) |=> ##1 !cal_o);
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int FRAME_W     = cfg_port_pkg::DEF_FRAME_W,
  parameter int ADDR_W      = cfg_port_pkg::DEF_ADDR_W,
  parameter int SYNC_STAGES = cfg_port_pkg::DEF_SYNC,
  parameter int CAL_REG     = cfg_port_pkg::DEF_CAL_REG,
  localparam int DATA_W     = FRAME_W - ADDR_W,
  localparam int NUM_REGS   = 1 << ADDR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ser_clk_i,
  input  logic                       ser_data_i,
  input  logic                       ser_latch_i,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs_o,
  output logic                       cal_start_o,
  output logic                       frame_err_o
);
  localparam int LN_CLK   = 0;
  localparam int LN_DATA  = 1;
  localparam int LN_LATCH = 2;

  logic [2:0]        ln_level, ln_rise, ln_fall;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  line_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_latch_i, ser_data_i, ser_clk_i}),
    .level_o (ln_level),
    .rise_o  (ln_rise),
    .fall_o  (ln_fall)
  );

  frame_shifter #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_rise_i   (ln_rise[LN_CLK]),
    .bit_val_i    (ln_level[LN_DATA]),
    .latch_lvl_i  (ln_level[LN_LATCH]),
    .latch_rise_i (ln_rise[LN_LATCH]),
    .wr_stb_o     (wr_stb),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .err_stb_o    (frame_err_o)
  );

  reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAL_REG(CAL_REG)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .regs_o    (cfg_regs_o),
    .cal_o     (cal_start_o)
  );

  // R3: input assumption, at most one line edge per synchronized cycle
  line_edge_sep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ln_rise, ln_fall}));
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!cal_start_o && !frame_err_o));
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, slatch = 1'b0;
  logic [16*DW-1:0] regs;
  logic cal, ferr;

  int tests = 0, fails = 0;
  int cyc = 0, cal_cnt = 0, err_cnt = 0, cal_run = 0, cal_run_max = 0;
  int err_run = 0, err_run_max = 0, r15_chg_cyc = -1, cal_cyc = -1;
  logic [DW-1:0] r15_prev = '0;
  logic [DW-1:0] model [16];
  bit done = 0;

  serial_cfg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdata),
    .ser_latch_i(slatch), .cfg_regs_o(regs), .cal_start_o(cal), .frame_err_o(ferr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (cal) begin cal_run++; if (cal_run == 1) begin cal_cnt++; cal_cyc = cyc; end end
    else cal_run = 0;
    if (cal_run > cal_run_max) cal_run_max = cal_run;
    if (ferr) begin err_run++; if (err_run == 1) err_cnt++; end else err_run = 0;
    if (err_run > err_run_max) err_run_max = err_run;
    if (regs[15*DW +: DW] != r15_prev) begin r15_chg_cyc = cyc; r15_prev = regs[15*DW +: DW]; end
  end

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic shift_bits(input logic [63:0] v, input int n, input bit wiggle);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = v[i]; clks(3);
      sclk = 1'b1; clks(3);
      if (wiggle) begin sdata = ~v[i]; clks(3); end
      sclk = 1'b0; clks(3);
    end
    sdata = 1'b0; clks(3);
  endtask

  task automatic latch_pulse();
    slatch = 1'b1; clks(4);
    slatch = 1'b0; clks(10);
  endtask

  task automatic send(input logic [3:0] a, input logic [DW-1:0] d, input bit wiggle);
    shift_bits({32'b0, d, a}, 32, wiggle);
    latch_pulse();
    model[a] = d;
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 16; a++) check(req, regs[a*DW +: DW], model[a]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 regs", regs, 0);
    check("R1 cal", cal, 0);
    check("R1 err", ferr, 0);
  endtask

  task automatic t_basic();
    int c0 = cal_cnt, e0 = err_cnt;
    send(4'd3, 28'hABCDE12, 0);
    check("R2 reg3", regs[3*DW +: DW], 28'hABCDE12);
    check_all("R8 others");
    check("R6 no cal", cal_cnt - c0, 0);
    send(4'd0, 28'h8000001, 0);
    send(4'd14, 28'h5A5A5A5, 0);
    check("R2 reg0", regs[0 +: DW], 28'h8000001);
    check_all("R8 multi");
    check("R6 no cal multi", cal_cnt - c0, 0);
    check("R2 no err", err_cnt - e0, 0);
  endtask

  task automatic t_edge();
    send(4'd7, 28'h3C0FF0A, 1);
    check("R3 rise sample", regs[7*DW +: DW], 28'h3C0FF0A);
  endtask

  task automatic t_bad_len();
    int e0 = err_cnt;
    shift_bits({32'b0, 28'hFFFFFFF, 4'd5}, 31, 0);
    latch_pulse();
    check("R4 short err", err_cnt - e0, 1);
    check_all("R4 short unchanged");
    shift_bits({31'b0, 1'b1, 28'h1234567, 4'd3}, 33, 0);
    latch_pulse();
    check("R4 long err", err_cnt - e0, 2);
    check("R4 err width", err_run_max, 1);
    check_all("R4 long unchanged");
    send(4'd5, 28'h0FEDCBA, 0);
    check("R7 after discard", regs[5*DW +: DW], 28'h0FEDCBA);
  endtask

  task automatic t_latch_high();
    slatch = 1'b1; clks(4);
    for (int i = 0; i < 5; i++) begin sclk = 1'b1; clks(3); sclk = 1'b0; clks(3); end
    slatch = 1'b0; clks(4);
    send(4'd9, 28'h1111111, 0);
    check("R7 latch-high clocks ignored", regs[9*DW +: DW], 28'h1111111);
    check_all("R7 bank");
  endtask

  task automatic t_cal();
    int c0 = cal_cnt;
    send(4'd15, 28'h2468ACE, 0);
    check("R5 reg15", regs[15*DW +: DW], 28'h2468ACE);
    check("R5 one pulse", cal_cnt - c0, 1);
    check("R5 one cycle after update", cal_cyc - r15_chg_cyc, 1);
    send(4'd15, 28'h2468ACE, 0);
    check("R5 same value pulse", cal_cnt - c0, 2);
    check("R5 width", cal_run_max, 1);
    check_all("R8 after cal");
  endtask

  initial begin
    for (int a = 0; a < 16; a++) model[a] = '0;
    clks(3);
    rst_n = 1'b1;
    clks(2);
    t_reset();
    t_basic();
    t_edge();
    t_bad_len();
    t_latch_high();
    t_cal();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule